// File: doc/BRIEF.md
# Optical Black Level Servo

This block closes the digital side of a black-level loop in an imaging front end. Each line of the imager carries a short run of shielded pixels. A clamp pulse marks that run, and while the pulse is active the block compares every 12-bit converter word with a programmable black target. It sums the signed difference over the run. When the run ends, it turns the scaled sum into one bounded step on an 8-bit correction code. That code feeds an offset DAC placed ahead of the converter, so the black pixels settle on the target over successive lines. Between runs the code is held.

Software can switch the loop off. While the loop is off, the target value drives the DAC directly as a fixed, programmable offset, and the learned correction is kept for when the loop is switched back on.

Top module: `black_level_servo`

## Requirements
- R1: After reset, with the loop enabled, `dac_code` is 128 (mid-scale).
- R2: `clamp_pol` = 1 makes `clamp_in` active high; `clamp_pol` = 0 makes it active low.
- R3: A window is a run of consecutive clock edges at which the clamp pulse is active. `dac_code` changes only at the first edge after a window at which the pulse is inactive (the trailing edge). It stays constant during windows and between them.
- R4: At the trailing edge the window sum S = Σ(sample − target) sets the step size. The step is (|S| >> 4), with a minimum of 1 and a maximum of 16. A positive S lowers the code and a negative S raises it.
- R5: A window whose sum S is exactly 0 leaves the code unchanged.
- R6: The code saturates at 0 and at 255 and never wraps.
- R7: When `loop_en` = 0, `dac_code` equals `black_target`, and clamp pulses do not alter the held correction. Once `loop_en` returns to 1, `dac_code` shows the correction that was held before the loop was disabled.
- R8: A window one pixel long produces a step (for S = 1, the code falls by 1).
- R9: Only the first 1024 samples of a window enter the sum. Samples after that in the same window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | 1 = loop tracks, 0 = target used as fixed offset |
| clamp_pol | input | 1 | Active level of `clamp_in` (1 = high) |
| clamp_in | input | 1 | Black-pixel window pulse |
| pix_sample | input | 12 | Converter output word |
| black_target | input | 8 | Black level target in converter LSBs |
| dac_code | output | 8 | Offset DAC correction code |

## Verification
A corrupted window sum or a wrong window count shows up as a wrong step size at the next trailing edge, one clock after the pulse drops. A wrong direction flag moves the code the opposite way in that same cycle. A polarity or edge-detect fault either moves `dac_code` in the middle of a window or fails to move it at the trailing edge, so checking the code on every pixel of a window catches it within one line. A saturation fault is visible as a wrap from 0 to a high code, or from 255 to a low code, on the first step past the rail.

// File: rtl/blc_pkg.sv
package blc_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_UP   = 2'd2
   } step_dir_e;
endpackage

// File: rtl/blc_window_detect.sv
module blc_window_detect #(
   parameter bit POL_PROGRAMMABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_en,
   input  logic clamp_pol,
   input  logic clamp_in,
   output logic win_act,
   output logic win_trail
);
   logic level_ok;
   logic act_prev_q;

   generate
      if (POL_PROGRAMMABLE) begin : g_pol_sel
         assign level_ok = clamp_pol ? clamp_in : ~clamp_in;
      end else begin : g_pol_high
         assign level_ok = clamp_in;
      end
   endgenerate

   assign win_act   = loop_en & level_ok;
   assign win_trail = loop_en & act_prev_q & ~level_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) act_prev_q <= 1'b0;
      else        act_prev_q <= win_act;
   end
endmodule

// File: rtl/blc_err_accum.sv
module blc_err_accum #(
   parameter int SAMPLE_W = 12,
   parameter int TGT_W    = 8,
   parameter int MAX_WIN  = 1024,
   parameter int ACC_W    = SAMPLE_W + 2 + $clog2(MAX_WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    win_act,
   input  logic [SAMPLE_W-1:0]     pix_sample,
   input  logic [TGT_W-1:0]        black_target,
   output logic signed [ACC_W-1:0] win_sum
);
   localparam int ERR_W = SAMPLE_W + 1;
   localparam int CNT_W = $clog2(MAX_WIN + 1);

   logic signed [ERR_W-1:0] err;
   logic signed [ACC_W-1:0] err_ext;
   logic [CNT_W-1:0]        cnt_q;
   logic signed [ACC_W-1:0] sum_q;
   logic                    room;

   assign err     = $signed({1'b0, pix_sample}) -
                    $signed({{(ERR_W-TGT_W){1'b0}}, black_target});
   assign err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
   assign room    = (cnt_q < CNT_W'(MAX_WIN));

   always_ff @(posedge clk) begin
      if (!rst_n || !win_act) begin
         cnt_q <= '0;
         sum_q <= '0;
      end else if (room) begin
         cnt_q <= cnt_q + 1'b1;
         sum_q <= sum_q + err_ext;
      end
   end

   assign win_sum = sum_q;
endmodule

// File: rtl/blc_step_shaper.sv
module blc_step_shaper
   import blc_pkg::*;
#(
   parameter int ACC_W    = 24,
   parameter int AVG_SH   = 4,
   parameter int STEP_MAX = 16,
   parameter int STEP_W   = $clog2(STEP_MAX + 1)
) (
   input  logic signed [ACC_W-1:0] win_sum,
   output step_dir_e               step_dir,
   output logic [STEP_W-1:0]       step_mag
);
   logic             neg;
   logic [ACC_W-1:0] mag_full;
   logic [ACC_W-1:0] mag_avg;

   assign neg      = win_sum[ACC_W-1];
   assign mag_full = neg ? ACC_W'(-win_sum) : ACC_W'(win_sum);

   generate
      if (AVG_SH == 0) begin : g_no_avg
         assign mag_avg = mag_full;
      end else begin : g_avg
         assign mag_avg = mag_full >> AVG_SH;
      end
   endgenerate

   always_comb begin
      if (mag_avg > ACC_W'(STEP_MAX))  step_mag = STEP_W'(STEP_MAX);
      else if (mag_avg == '0)          step_mag = STEP_W'(1);
      else                             step_mag = mag_avg[STEP_W-1:0];

      if (win_sum == '0)  step_dir = STEP_HOLD;
      else if (neg)       step_dir = STEP_UP;
      else                step_dir = STEP_DOWN;
   end
endmodule

// File: rtl/blc_corr_reg.sv
module blc_corr_reg
   import blc_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int STEP_W   = 5,
   parameter int RST_CODE = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_trail,
   input  step_dir_e         step_dir,
   input  logic [STEP_W-1:0] step_mag,
   output logic [CODE_W-1:0] corr_code
);
   localparam int WIDE_W = CODE_W + 1;
   localparam logic [WIDE_W-1:0] TOP = WIDE_W'((1 << CODE_W) - 1);

   logic [CODE_W-1:0] corr_q;
   logic [CODE_W-1:0] corr_nx;
   logic [WIDE_W-1:0] wide;
   logic [WIDE_W-1:0] mag_w;
   logic [WIDE_W-1:0] up_sum;

   assign wide   = {1'b0, corr_q};
   assign mag_w  = WIDE_W'(step_mag);
   assign up_sum = wide + mag_w;

   always_comb begin
      corr_nx = corr_q;
      unique case (step_dir)
         STEP_DOWN: corr_nx = (wide < mag_w) ? '0 : CODE_W'(wide - mag_w);
         STEP_UP:   corr_nx = (up_sum > TOP) ? TOP[CODE_W-1:0] : up_sum[CODE_W-1:0];
         default:   corr_nx = corr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          corr_q <= CODE_W'(RST_CODE);
      else if (win_trail)  corr_q <= corr_nx;
   end

   assign corr_code = corr_q;
endmodule

// File: rtl/black_level_servo.sv
module black_level_servo
   import blc_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int CODE_W   = 8,
   parameter int MAX_WIN  = 1024,
   parameter int AVG_SH   = 4,
   parameter int STEP_MAX = 16,
   parameter int RST_CODE = 128,
   parameter bit POL_PROGRAMMABLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                loop_en,
   input  logic                clamp_pol,
   input  logic                clamp_in,
   input  logic [SAMPLE_W-1:0] pix_sample,
   input  logic [CODE_W-1:0]   black_target,
   output logic [CODE_W-1:0]   dac_code
);
   localparam int ACC_W  = SAMPLE_W + 2 + $clog2(MAX_WIN);
   localparam int STEP_W = $clog2(STEP_MAX + 1);

   generate
      if (CODE_W > SAMPLE_W) begin : g_bad_code_w
         $error("black_level_servo: CODE_W must not exceed SAMPLE_W");
      end
      if (STEP_MAX < 1 || STEP_W > CODE_W) begin : g_bad_step
         $error("black_level_servo: STEP_MAX out of range");
      end
      if (RST_CODE < 0 || RST_CODE >= (1 << CODE_W)) begin : g_bad_rst
         $error("black_level_servo: RST_CODE out of range");
      end
      if (MAX_WIN < 1) begin : g_bad_win
         $error("black_level_servo: MAX_WIN must be positive");
      end
   endgenerate

   logic                    win_act;
   logic                    win_trail;
   logic signed [ACC_W-1:0] win_sum;
   step_dir_e               step_dir;
   logic [STEP_W-1:0]       step_mag;
   logic [CODE_W-1:0]       corr_code;

   blc_window_detect #(.POL_PROGRAMMABLE(POL_PROGRAMMABLE)) u_win (
      .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clamp_pol(clamp_pol),
      .clamp_in(clamp_in), .win_act(win_act), .win_trail(win_trail)
   );

   blc_err_accum #(
      .SAMPLE_W(SAMPLE_W), .TGT_W(CODE_W), .MAX_WIN(MAX_WIN), .ACC_W(ACC_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .win_act(win_act), .pix_sample(pix_sample),
      .black_target(black_target), .win_sum(win_sum)
   );

   blc_step_shaper #(
      .ACC_W(ACC_W), .AVG_SH(AVG_SH), .STEP_MAX(STEP_MAX), .STEP_W(STEP_W)
   ) u_shape (
      .win_sum(win_sum), .step_dir(step_dir), .step_mag(step_mag)
   );

   blc_corr_reg #(
      .CODE_W(CODE_W), .STEP_W(STEP_W), .RST_CODE(RST_CODE)
   ) u_corr (
      .clk(clk), .rst_n(rst_n), .win_trail(win_trail), .step_dir(step_dir),
      .step_mag(step_mag), .corr_code(corr_code)
   );

   assign dac_code = loop_en ? corr_code : black_target;
endmodule

// File: rtl/black_level_servo_chk.sv
module black_level_servo_chk #(
   parameter int CODE_W   = 8,
   parameter int STEP_MAX = 16,
   parameter int RST_CODE = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              loop_en,
   input logic              clamp_pol,
   input logic              clamp_in,
   input logic [CODE_W-1:0] black_target,
   input logic [CODE_W-1:0] dac_code
);
   logic              on_lvl;
   logic              seen_on_q;
   logic              edge_end;
   logic [CODE_W-1:0] dac_prev_q;
   int                delta;

   assign on_lvl   = loop_en & (clamp_pol ? clamp_in : ~clamp_in);
   assign edge_end = loop_en & seen_on_q & ~on_lvl;
   assign delta    = int'(dac_code) - int'(dac_prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) seen_on_q <= 1'b0;
      else        seen_on_q <= on_lvl;
      dac_prev_q <= dac_code;
   end

   // R1
   reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && loop_en) |-> (dac_code == CODE_W'(RST_CODE)));

   // R7
   bypass_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |-> (dac_code == black_target));

   // R3
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && $past(loop_en) && !$past(edge_end)) |-> $stable(dac_code));

   // R4
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && $past(loop_en)) |-> (delta <= STEP_MAX && delta >= -STEP_MAX));
endmodule

bind black_level_servo black_level_servo_chk #(
   .CODE_W(CODE_W), .STEP_MAX(STEP_MAX), .RST_CODE(RST_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clamp_pol(clamp_pol),
   .clamp_in(clamp_in), .black_target(black_target), .dac_code(dac_code)
);

// File: tb/black_level_servo_bench.sv
module black_level_servo_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        loop_en;
   logic        clamp_pol;
   logic        clamp_in;
   logic [11:0] pix_sample;
   logic [7:0]  black_target;
   logic [7:0]  dac_code;

   int n_run  = 0;
   int n_fail = 0;
   int exp_code;
   bit done = 1'b0;

   always #2 clk = ~clk;

   black_level_servo u_black_level_servo (
      .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clamp_pol(clamp_pol),
      .clamp_in(clamp_in), .pix_sample(pix_sample), .black_target(black_target),
      .dac_code(dac_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_step(input int code, input longint s);
      longint m;
      int r;
      if (s == 0) return code;
      m = (s < 0 ? -s : s) >>> 4;
      if (m > 16) m = 16;
      if (m == 0) m = 1;
      r = (s > 0) ? code - int'(m) : code + int'(m);
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   function automatic int clip12(input int v);
      if (v < 0) return 0;
      if (v > 4095) return 4095;
      return v;
   endfunction

   // Window of n samples: first n-tail take val_a/val_b alternating, last tail take val_t.
   task automatic window(input string req, input int n, input int val_a,
                         input int val_b, input int tail, input int val_t);
      longint s = 0;
      int v;
      bit stable_ok = 1'b1;
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         v = (i >= n - tail) ? clip12(val_t) : clip12((i % 2 == 0) ? val_a : val_b);
         if (i < 1024) s += v - int'(black_target);
         clamp_in   = clamp_pol;
         pix_sample = 12'(v);
         @(negedge clk);
         if (int'(dac_code) != (loop_en ? exp_code : int'(black_target))) begin
            stable_ok = 1'b0;
            bad = dac_code;
         end
      end
      // R3: code held for the whole window
      chk("R3 hold in window", stable_ok ? 1 : bad, stable_ok ? 1 : exp_code);
      clamp_in = ~clamp_pol;
      @(negedge clk);
      if (loop_en) exp_code = model_step(exp_code, s);
      chk(req, dac_code, loop_en ? exp_code : int'(black_target));
      @(negedge clk);
      // R3: held after trailing edge
      chk("R3 hold after", dac_code, loop_en ? exp_code : int'(black_target));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; loop_en = 1'b1; clamp_pol = 1'b1; clamp_in = 1'b0;
      pix_sample = '0; black_target = 8'd128;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_code = 128;
      chk("R1 reset code", dac_code, 128);
   endtask

   task automatic t_basic;
      window("R4 positive sum step", 16, 136, 136, 0, 0);  // sum 128 -> -8
   endtask

   task automatic t_polarity;
      clamp_pol = 1'b0; clamp_in = 1'b1;
      @(negedge clk);
      chk("R2 low polarity idle", dac_code, exp_code);
      window("R2 active low window", 4, 108, 108, 0, 0);    // sum -80 -> +5
      clamp_pol = 1'b1; clamp_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_zero;
      window("R5 zero sum", 8, 133, 123, 0, 0);
   endtask

   task automatic t_single;
      window("R8 single pixel", 1, 129, 129, 0, 0);
   endtask

   task automatic t_sat_low;
      for (int k = 0; k < 12 && exp_code > 0; k++)
         window("R4 capped step", 64, 4095, 4095, 0, 0);
      window("R6 floor at 0", 64, 4095, 4095, 0, 0);
      chk("R6 floor value", dac_code, 0);
   endtask

   task automatic t_sat_high;
      black_target = 8'd255;
      @(negedge clk);
      for (int k = 0; k < 18 && exp_code < 255; k++)
         window("R4 upward step", 64, 0, 0, 0, 0);
      window("R6 ceiling at 255", 64, 0, 0, 0, 0);
      chk("R6 ceiling value", dac_code, 255);
      black_target = 8'd128;
      @(negedge clk);
   endtask

   task automatic t_bypass;
      int held;
      held = exp_code;
      loop_en = 1'b0; black_target = 8'd77;
      @(negedge clk);
      chk("R7 target passthrough", dac_code, 77);
      window("R7 pulses ignored when off", 10, 4095, 4095, 0, 0);
      black_target = 8'd128; loop_en = 1'b1;
      @(negedge clk);
      chk("R7 held correction restored", dac_code, held);
   endtask

   task automatic t_cap;
      window("R9 samples beyond cap ignored", 1030, 128, 128, 6, 4095);
   endtask

   initial begin
      t_reset;
      t_basic;
      t_polarity;
      t_zero;
      t_single;
      t_cap;
      t_sat_low;
      t_sat_high;
      t_bypass;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule